// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block is the 64-bit execution stage for the register-arithmetic instruction classes of a packet-filter virtual machine. Each request carries a 4-bit operation code, a width select (64-bit or 32-bit), the current destination register value and a second operand. The second operand is either a register value or a 32-bit immediate that is sign-extended. The block returns one result per accepted request, marked by a one-cycle valid strobe. An illegal request also raises an illegal flag.

Most operations finish in the cycle after they are accepted. Unsigned and signed divide and modulo run on an iterative divider that produces one quotient bit per cycle. While it works, `busy` is high, and any request offered during that time is dropped. The signed divide and modulo codes exist only when the extension enable is high. Byte-order conversion takes its width from the immediate and its direction from the source-select bit.

Top module: `pfvm_alu`

## Requirements
- R1: Codes 0 add, 1 subtract, 2 multiply (low 64 bits of the product), 4 or, 5 and and A xor produce `res_valid` with the result in the cycle after the request is accepted. A request is accepted when `op_valid` is high and `busy` is low.
- R2: With `op_wide`=0, every operation except code D uses only the low 32 bits of both operands, and the 32-bit result is zero-extended to 64 bits.
- R3: With `op_src_reg`=1 the second operand is `op_src`. With `op_src_reg`=0 it is `op_imm` sign-extended from bit 31.
- R4: Code 6 shifts left, code 7 shifts right logically and code C shifts right arithmetically. The shift amount is the low 6 bits of the second operand in 64-bit mode and the low 5 bits in 32-bit mode. In 32-bit mode, bit 31 is the sign bit for the arithmetic shift.
- R5: Code 8 returns the two's-complement negation of `op_dst` and ignores the second operand. Code B returns the second operand.
- R6: Code D converts byte order and ignores `op_wide`. `op_imm` must be 16, 32 or 64 and selects how many low bits of `op_dst` are used. With `op_src_reg`=1 those bytes are reversed; with `op_src_reg`=0 they pass unchanged. All bits above the selected width are zero. Any other `op_imm` value gives an illegal result.
- R7: Codes 3 (unsigned divide) and 9 (unsigned modulo) raise `busy` for exactly DATA_W cycles after the accepting edge. The result is presented with `res_valid` in the cycle in which `busy` falls.
- R8: With `ext_en`=1, codes E (signed divide) and F (signed modulo) use the same timing as R7. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 returns the most negative value, with remainder 0.
- R9: A divisor of zero does not trap. Divide returns 0 and modulo returns the dividend, in both signed and unsigned forms.
- R10: With `ext_en`=0, codes E and F complete in the next cycle with `res_illegal`=1 and `res_data`=0, and they do not start the divider.
- R11: Requests offered while `busy` is high are ignored and produce no result.
- R12: After reset, `res_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_code | input | 4 | Operation code |
| op_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| op_src_reg | input | 1 | Operand select; for code D, the byte-order direction |
| op_dst | input | 64 | Destination register value |
| op_src | input | 64 | Source register value |
| op_imm | input | 32 | Immediate value |
| ext_en | input | 1 | Enables signed divide and signed modulo |
| busy | output | 1 | Divider is working; requests are dropped |
| res_valid | output | 1 | Result strobe |
| res_illegal | output | 1 | The result belongs to an illegal request |
| res_data | output | 64 | Result value |

## Verification
The assertions check the timing contract on every cycle:
- every non-divide request gets its strobe in the next cycle;
- a disabled signed code is reported illegal without raising `busy`;
- a divide holds `busy` for exactly DATA_W cycles and ends with the strobe;
- no strobe appears without a cause;
- narrow results and 16-bit conversions keep their upper bits clear.

The arithmetic values themselves can only be shown by the bench scenarios, which compare against a behavioural model. These values cover signed truncation, the most-negative-by-minus-one case, zero divisors, shift masking, sign-extended immediates and the byte-order directions.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_MUL   = 4'h2,
    OP_UDIV  = 4'h3,
    OP_OR    = 4'h4,
    OP_AND   = 4'h5,
    OP_SHL   = 4'h6,
    OP_SHR   = 4'h7,
    OP_NEG   = 4'h8,
    OP_UMOD  = 4'h9,
    OP_XOR   = 4'hA,
    OP_MOV   = 4'hB,
    OP_SAR   = 4'hC,
    OP_BSWAP = 4'hD,
    OP_SDIV  = 4'hE,
    OP_SMOD  = 4'hF
  } alu_op_e;

  function automatic logic op_uses_divider(input alu_op_e op);
    return op inside {OP_UDIV, OP_UMOD, OP_SDIV, OP_SMOD};
  endfunction

  function automatic logic op_needs_ext(input alu_op_e op);
    return op inside {OP_SDIV, OP_SMOD};
  endfunction

  function automatic logic op_wants_rem(input alu_op_e op);
    return op inside {OP_UMOD, OP_SMOD};
  endfunction

endpackage

// File: rtl/pfvm_alu_logic.sv
module pfvm_alu_logic
  import pfvm_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  alu_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int SH_N   = $clog2(HALF_W);

  function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic w);
    return w ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [SH_W-1:0] shamt(input logic [DATA_W-1:0] v, input logic w);
    return w ? v[SH_W-1:0] : {{(SH_W-SH_N){1'b0}}, v[SH_N-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] sar(input logic [DATA_W-1:0] v,
                                            input logic [SH_W-1:0] n, input logic w);
    logic [DATA_W-1:0] src;
    src = w ? v : {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
    return DATA_W'($signed(src) >>> n);
  endfunction

  logic [DATA_W-1:0] an, bn, raw;
  logic [SH_W-1:0]   sh;

  always_comb begin
    an = fit(a, wide);
    bn = fit(b, wide);
    sh = shamt(b, wide);
    case (op)
      OP_ADD:  raw = an + bn;
      OP_SUB:  raw = an - bn;
      OP_MUL:  raw = an * bn;
      OP_OR:   raw = an | bn;
      OP_AND:  raw = an & bn;
      OP_XOR:  raw = an ^ bn;
      OP_SHL:  raw = an << sh;
      OP_SHR:  raw = an >> sh;
      OP_SAR:  raw = sar(a, sh, wide);
      OP_NEG:  raw = '0 - an;
      OP_MOV:  raw = bn;
      default: raw = '0;
    endcase
    y = fit(raw, wide);
  end

endmodule

// File: rtl/pfvm_alu_bswap.sv
module pfvm_alu_bswap #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic              to_big,
  input  logic [31:0]       width_sel,
  output logic [DATA_W-1:0] y,
  output logic              bad_width
);
  localparam int NBYTES = DATA_W / 8;
  localparam int NSIZES = $clog2(NBYTES);

  logic [DATA_W-1:0] swapped [NSIZES];
  logic [DATA_W-1:0] kept    [NSIZES];
  logic [NSIZES-1:0] hit;

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int NB = 2 << k;
    for (genvar j = 0; j < NB; j++) begin : g_byte
      assign swapped[k][8*j +: 8] = a[8*(NB-1-j) +: 8];
      assign kept[k][8*j +: 8]    = a[8*j +: 8];
    end
    if (NB < NBYTES) begin : g_pad
      assign swapped[k][DATA_W-1:8*NB] = '0;
      assign kept[k][DATA_W-1:8*NB]    = '0;
    end
    assign hit[k] = (width_sel == 32'(8 * NB));
  end

  always_comb begin
    y = '0;
    for (int k = 0; k < NSIZES; k++)
      if (hit[k]) y = to_big ? swapped[k] : kept[k];
    bad_width = ~|hit;
  end

endmodule

// File: rtl/pfvm_alu_divider.sv
module pfvm_alu_divider #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_op,
  input  logic              want_rem,
  input  logic              wide,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  function automatic logic [DATA_W-1:0] extend(input logic [DATA_W-1:0] v,
                                               input logic w, input logic s);
    if (w) return v;
    return s ? {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]} : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v, input logic s);
    return (s && v[DATA_W-1]) ? '0 - v : v;
  endfunction

  logic [DATA_W-1:0] quo_q, rem_q, dvs_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;
  logic              neg_q_q, neg_r_q, zero_q, rem_sel_q, wide_q;

  logic [DATA_W-1:0] ext_a, ext_b;
  logic [DATA_W:0]   shifted, diff;
  logic              step_fire, last_step, fits;
  logic [DATA_W-1:0] nxt_rem, nxt_quo;

  assign ext_a     = extend(dividend, wide, signed_op);
  assign ext_b     = extend(divisor, wide, signed_op);
  assign step_fire = busy_q;
  assign last_step = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    shifted = {rem_q, quo_q[DATA_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
    nxt_rem = fits ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
    nxt_quo = {quo_q[DATA_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0; rem_q <= '0; dvs_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
      neg_q_q <= 1'b0; neg_r_q <= 1'b0; zero_q <= 1'b0;
      rem_sel_q <= 1'b0; wide_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (start && !busy_q) begin
        quo_q     <= magnitude(ext_a, signed_op);
        rem_q     <= '0;
        dvs_q     <= magnitude(ext_b, signed_op);
        cnt_q     <= CNT_W'(DATA_W);
        busy_q    <= 1'b1;
        neg_r_q   <= signed_op && ext_a[DATA_W-1];
        neg_q_q   <= signed_op && (ext_a[DATA_W-1] ^ ext_b[DATA_W-1]);
        zero_q    <= (ext_b == '0);
        rem_sel_q <= want_rem;
        wide_q    <= wide;
      end else if (step_fire) begin
        quo_q <= nxt_quo;
        rem_q <= nxt_rem;
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_step) busy_q <= 1'b0;
      end
    end
  end

  logic [DATA_W-1:0] q_fix, r_fix, pick;
  always_comb begin
    q_fix  = zero_q ? '0 : (neg_q_q ? '0 - quo_q : quo_q);
    r_fix  = neg_r_q ? '0 - rem_q : rem_q;
    pick   = rem_sel_q ? r_fix : q_fix;
    result = wide_q ? pick : {{HALF_W{1'b0}}, pick[HALF_W-1:0]};
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
  import pfvm_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              op_wide,
  input  logic              op_src_reg,
  input  logic [DATA_W-1:0] op_dst,
  input  logic [DATA_W-1:0] op_src,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              ext_en,
  output logic              busy,
  output logic              res_valid,
  output logic              res_illegal,
  output logic [DATA_W-1:0] res_data
);
  alu_op_e           op;
  logic              accept, div_go, ext_block, is_div, illegal_now;
  logic [DATA_W-1:0] operand, logic_y, swap_y, single_y;
  logic              swap_bad;
  logic              div_busy, div_done;
  logic [DATA_W-1:0] div_res;

  logic              one_valid_q, one_ill_q;
  logic [DATA_W-1:0] one_data_q;

  assign op        = alu_op_e'(op_code);
  assign operand   = op_src_reg ? op_src : {{(DATA_W-IMM_W){op_imm[IMM_W-1]}}, op_imm};
  assign accept    = op_valid && !div_busy;
  assign ext_block = op_needs_ext(op) && !ext_en;
  assign is_div    = op_uses_divider(op) && !ext_block;
  assign div_go    = accept && is_div;

  pfvm_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .wide(op_wide), .a(op_dst), .b(operand), .y(logic_y)
  );

  pfvm_alu_bswap #(.DATA_W(DATA_W)) u_bswap (
    .a(op_dst), .to_big(op_src_reg), .width_sel(32'(op_imm)),
    .y(swap_y), .bad_width(swap_bad)
  );

  pfvm_alu_divider #(.DATA_W(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go),
    .signed_op(op_needs_ext(op)), .want_rem(op_wants_rem(op)), .wide(op_wide),
    .dividend(op_dst), .divisor(operand),
    .busy(div_busy), .done(div_done), .result(div_res)
  );

  assign illegal_now = ext_block || (op == OP_BSWAP && swap_bad);
  assign single_y    = illegal_now ? '0 : (op == OP_BSWAP ? swap_y : logic_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_valid_q <= 1'b0;
      one_ill_q   <= 1'b0;
      one_data_q  <= '0;
    end else begin
      one_valid_q <= accept && !is_div;
      one_ill_q   <= accept && !is_div && illegal_now;
      if (accept && !is_div) one_data_q <= single_y;
    end
  end

  assign busy        = div_busy;
  assign res_valid   = one_valid_q || div_done;
  assign res_illegal = one_valid_q && one_ill_q;
  assign res_data    = div_done ? div_res : one_data_q;

endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic              op_wide,
  input logic [IMM_W-1:0]  op_imm,
  input logic              ext_en,
  input logic              busy,
  input logic              res_valid,
  input logic              res_illegal,
  input logic [DATA_W-1:0] res_data,
  input logic              div_done
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 2);

  logic accept, divc, ext_code;
  logic [CNT_W-1:0] busy_run;

  assign accept   = op_valid && !busy;
  assign divc     = op_code inside {4'h3, 4'h9, 4'hE, 4'hF};
  assign ext_code = op_code inside {4'hE, 4'hF};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= busy ? busy_run + CNT_W'(1) : '0;
  end

  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !divc |=> res_valid && !busy);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !op_wide && !divc && op_code != 4'hD |=> res_data[DATA_W-1:HALF_W] == '0);

  a_r6_narrow_swap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code == 4'hD && op_imm == IMM_W'(16) |=> res_data[DATA_W-1:16] == '0 && !res_illegal);

  a_r7_div_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code inside {4'h3, 4'h9} |=> busy && !res_valid);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == CNT_W'(DATA_W) && res_valid && div_done);

  a_r8_ext_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ext_code && ext_en |=> busy);

  a_r10_ext_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ext_code && !ext_en |=> res_valid && res_illegal && res_data == '0 && !busy);

  a_r11_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid);

  a_r11_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(accept) || $fell(busy));

endmodule

bind pfvm_alu pfvm_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_wide(op_wide), .op_imm(op_imm), .ext_en(ext_en), .busy(busy),
  .res_valid(res_valid), .res_illegal(res_illegal), .res_data(res_data),
  .div_done(div_done)
);

// File: tb/tb_pfvm_alu.sv
module tb_pfvm_alu;
  localparam int DATA_W = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_wide = 1'b1, op_src_reg = 1'b0, ext_en = 1'b0;
  logic [3:0]  op_code = '0;
  logic [63:0] op_dst = '0, op_src = '0;
  logic [31:0] op_imm = '0;
  logic busy, res_valid, res_illegal;
  logic [63:0] res_data;

  pfvm_alu dut (.*);

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  bit armed = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [63:0] data; logic ill; string tag; } exp_t;
  exp_t q[$];
  int bs = -1, be = -2;
  string last_tag = "R12";

  function automatic logic [31:0] calc32(input [3:0] c, input [31:0] a, input [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (c)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h3: return (b == 0) ? 32'd0 : a / b;
      4'h4: return a | b;
      4'h5: return a & b;
      4'h6: return a << b[4:0];
      4'h7: return a >> b[4:0];
      4'h8: return -a;
      4'h9: return (b == 0) ? a : a % b;
      4'hA: return a ^ b;
      4'hB: return b;
      4'hC: return 32'($signed(a) >>> b[4:0]);
      4'hE: return (sb == 0) ? 0 : (sa == 32'sh80000000 && sb == -1) ? sa : sa / sb;
      default: return (sb == 0) ? sa : (sa == 32'sh80000000 && sb == -1) ? 0 : sa % sb;
    endcase
  endfunction

  function automatic logic [63:0] calc64(input [3:0] c, input [63:0] a, input [63:0] b);
    longint sa, sb;
    sa = a; sb = b;
    case (c)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h3: return (b == 0) ? 64'd0 : a / b;
      4'h4: return a | b;
      4'h5: return a & b;
      4'h6: return a << b[5:0];
      4'h7: return a >> b[5:0];
      4'h8: return -a;
      4'h9: return (b == 0) ? a : a % b;
      4'hA: return a ^ b;
      4'hB: return b;
      4'hC: return 64'($signed(a) >>> b[5:0]);
      4'hE: return (sb == 0) ? 0 : (sa == 64'sh8000000000000000 && sb == -1) ? sa : sa / sb;
      default: return (sb == 0) ? sa : (sa == 64'sh8000000000000000 && sb == -1) ? 0 : sa % sb;
    endcase
  endfunction

  function automatic void model(input [3:0] c, input w, input s, input [63:0] d,
                                input [63:0] r, input [31:0] im, input e,
                                output logic [63:0] y, output logic ill, output logic dv);
    logic [63:0] b, t64;
    logic [31:0] t32;
    logic [15:0] t16;
    b = s ? r : {{32{im[31]}}, im};
    y = '0; ill = 0; dv = 0;
    if (c == 4'hD) begin
      t16 = {<<8{d[15:0]}}; t32 = {<<8{d[31:0]}}; t64 = {<<8{d}};
      if (im == 16)      y = s ? {48'd0, t16} : {48'd0, d[15:0]};
      else if (im == 32) y = s ? {32'd0, t32} : {32'd0, d[31:0]};
      else if (im == 64) y = s ? t64 : d;
      else ill = 1;
      return;
    end
    if ((c == 4'hE || c == 4'hF) && !e) begin ill = 1; return; end
    dv = (c == 4'h3 || c == 4'h9 || c == 4'hE || c == 4'hF);
    y = w ? calc64(c, d, b) : {32'd0, calc32(c, d[31:0], b[31:0])};
  endfunction

  task automatic send(input [3:0] c, input w, input s, input [63:0] d, input [63:0] r,
                      input [31:0] im, input e, input string tag);
    logic [63:0] y; logic ill, dv; exp_t x;
    @(negedge clk);
    op_valid = 1; op_code = c; op_wide = w; op_src_reg = s;
    op_dst = d; op_src = r; op_imm = im; ext_en = e;
    last_tag = tag;
    if (cyc >= bs && cyc <= be) return;
    model(c, w, s, d, r, im, e, y, ill, dv);
    x.data = y; x.ill = ill; x.tag = tag;
    x.due = dv ? cyc + 1 + DATA_W : cyc + 1;
    if (dv) begin bs = cyc + 1; be = cyc + DATA_W; end
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (q.size() != 0 || (cyc >= bs && cyc <= be)) idle(1);
    idle(1);
  endtask

  always @(negedge clk) begin
    if (armed) begin
      logic want, bexp;
      want = (q.size() != 0) && (q[0].due == cyc);
      bexp = (cyc >= bs && cyc <= be);
      checks++;
      if (busy !== bexp) begin
        errors++;
        $display("FAIL %s busy: actual %b expected %b at cycle %0d", last_tag, busy, bexp, cyc);
      end
      checks++;
      if (res_valid !== want) begin
        errors++;
        $display("FAIL %s res_valid: actual %b expected %b at cycle %0d",
                 want ? q[0].tag : last_tag, res_valid, want, cyc);
      end else if (want) begin
        checks++;
        if (res_data !== q[0].data || res_illegal !== q[0].ill) begin
          errors++;
          $display("FAIL %s result: actual %h/%b expected %h/%b", q[0].tag,
                   res_data, res_illegal, q[0].data, q[0].ill);
        end
      end
      if (want) void'(q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] NEG1  = '1;

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual %b%b expected 00", res_valid, busy);
    end
    armed = 1;
    // R1 register operand, back to back
    send(4'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h25, 0, 0, "R1");
    send(4'h1, 1, 1, 64'h10, 64'h25, 0, 0, "R1");
    send(4'h2, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0, 0, "R1");
    send(4'h4, 1, 1, 64'hF0F0, 64'h0F0F_0000_0000_0000, 0, 0, "R1");
    send(4'h5, 1, 1, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 0, 0, "R1");
    send(4'hA, 1, 1, 64'hAAAA_5555_AAAA_5555, 64'hFFFF_0000_FFFF_0000, 0, 0, "R1");
    // R3 immediates
    send(4'h0, 1, 0, 64'h100, 64'hDEAD, 32'hFFFF_FFFE, 0, "R3");
    send(4'h0, 1, 0, 64'h100, 64'hDEAD, 32'h7FFF_FFFF, 0, "R3");
    // R2 narrow
    send(4'h0, 0, 1, 64'h1234_5678_FFFF_FFFF, 64'h2, 0, 0, "R2");
    send(4'h1, 0, 0, 64'hFFFF_FFFF_0000_0000, 0, 32'd1, 0, "R2");
    send(4'h2, 0, 1, 64'hAAAA_AAAA_0001_0001, 64'h5555_5555_0001_0001, 0, 0, "R2");
    // R4 shifts
    send(4'h6, 1, 0, 64'h1, 0, 32'd70, 0, "R4");
    send(4'h7, 1, 0, MIN64, 0, 32'd63, 0, "R4");
    send(4'hC, 1, 0, MIN64, 0, 32'd4, 0, "R4");
    send(4'h6, 0, 0, 64'h1, 0, 32'd33, 0, "R4");
    send(4'hC, 0, 0, 64'h0000_0000_8000_0000, 0, 32'd31, 0, "R4");
    send(4'h7, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'd36, 0, 0, "R4");
    // R5 negate, move
    send(4'h8, 1, 1, 64'd5, 64'hFFFF, 32'h1234, 0, "R5");
    send(4'h8, 0, 0, 64'd5, 64'hFFFF, 32'h1234, 0, "R5");
    send(4'hB, 1, 0, 64'hFFFF, 0, 32'h8000_0001, 0, "R5");
    send(4'hB, 0, 1, 64'hFFFF, 64'h9999_8888_7777_6666, 0, 0, "R5");
    // R6 byte order
    for (int dir = 0; dir < 2; dir++) begin
      send(4'hD, 1, dir[0], 64'h0102_0304_0506_0708, 0, 32'd16, 0, "R6");
      send(4'hD, 0, dir[0], 64'h0102_0304_0506_0708, 0, 32'd32, 0, "R6");
      send(4'hD, 0, dir[0], 64'h0102_0304_0506_0708, 0, 32'd64, 0, "R6");
    end
    send(4'hD, 1, 1, 64'h0102_0304_0506_0708, 0, 32'd8, 0, "R6");
    // R10 disabled signed codes
    send(4'hE, 1, 1, 64'd100, 64'd7, 0, 0, "R10");
    send(4'hF, 0, 1, 64'd100, 64'd7, 0, 0, "R10");
    drain();
    // R7 unsigned divide/modulo
    send(4'h3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 0, 0, "R7"); drain();
    send(4'h9, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 0, 0, "R7"); drain();
    send(4'h3, 0, 0, 64'h5_0000_0064, 0, 32'hFFFF_FFF9, 0, "R7"); drain();
    send(4'h9, 0, 1, 64'h7_FFFF_FFFF, 64'h3_0000_0010, 0, 0, "R7"); drain();
    // R8 signed
    send(4'hE, 1, 0, -64'sd100, 0, 32'd7, 1, "R8"); drain();
    send(4'hF, 1, 0, -64'sd100, 0, 32'd7, 1, "R8"); drain();
    send(4'hF, 1, 0, 64'd100, 0, -32'sd7, 1, "R8"); drain();
    send(4'hE, 1, 1, MIN64, NEG1, 0, 1, "R8"); drain();
    send(4'hF, 1, 1, MIN64, NEG1, 0, 1, "R8"); drain();
    send(4'hE, 0, 0, 64'h1234_5678_8000_0000, 0, 32'hFFFF_FFFF, 1, "R8"); drain();
    send(4'hF, 0, 0, 64'h0000_0000_FFFF_FF9C, 0, 32'd7, 1, "R8"); drain();
    // R9 zero divisor
    send(4'h3, 1, 1, 64'd77, 64'd0, 0, 0, "R9"); drain();
    send(4'h9, 1, 1, 64'd77, 64'd0, 0, 0, "R9"); drain();
    send(4'hF, 1, 1, -64'sd77, 64'd0, 0, 1, "R9"); drain();
    send(4'hE, 0, 0, -64'sd77, 64'd0, 0, 1, "R9"); drain();
    send(4'hF, 0, 1, 64'hABCD_0000_FFFF_FFB3, 64'h1_0000_0000, 0, 1, "R9"); drain();
    // R11 requests during busy are dropped
    send(4'h3, 1, 1, 64'd1000, 64'd3, 0, 0, "R11");
    send(4'h0, 1, 1, 64'd1, 64'd1, 0, 0, "R11");
    send(4'hB, 1, 0, 64'd1, 0, 32'd9, 0, "R11");
    idle(20);
    send(4'h9, 1, 1, 64'd5, 64'd2, 0, 0, "R11");
    drain();
    send(4'h0, 1, 1, 64'd2, 64'd3, 0, 0, "R11");
    drain();
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule